// File: doc/BRIEF.md
# Transmit Packet Framer

This block produces the byte stream that a modulator sends for one packet. A start strobe begins a packet. The block first emits a run of preamble bytes and a 16-bit sync word. It then pulls bytes from the first-word-fall-through read port of a transmit FIFO and passes them on. Last, it appends a two-byte CRC when the CRC is enabled. When whitening is enabled, every byte after the sync word is scrambled with a 9-bit pseudo-random sequence. This covers the length byte, the payload and the CRC bytes.

The packet length comes from one of two places. In variable mode, the first FIFO byte is a length byte, and its value gives the number of FIFO bytes that follow it. If the receiver filters on address, the address byte is counted among them. In fixed mode, a configuration input gives the payload length and no length byte is sent. In that mode the first FIFO byte is the address byte when the receiver filters on address.

The modulator may ask for a byte while the packet is unfinished and the FIFO is empty. The block then locks into an underflow state. Only a flush command releases it. Bytes written to the FIFO later do not resume the packet. Every byte leaves through a valid/ready handshake. A one-cycle done pulse marks a completed packet.

Top module: `pkt_framer`

## Requirements
- R1: While reset is high and in the cycles after it, tx_valid_o, fifo_rd_o, done_o and underflow_o are all 0. No FIFO byte is read before a start strobe.
- R2: After a start strobe seen in idle, the block sends cfg_pre_count_i bytes of value 0xAA, or none when the count is 0. It then sends cfg_sync_i[15:8] and then cfg_sync_i[7:0]. These bytes are never whitened.
- R3: With cfg_var_len_i=1, the first FIFO byte L is sent as the length byte. Exactly L further FIFO bytes follow it, so L+1 bytes are popped in total. L=0 sends only the length byte.
- R4: With cfg_var_len_i=0, exactly cfg_fixed_len_i FIFO bytes are popped and sent, with no length byte. A length of 0 sends no FIFO byte at all.
- R5: With cfg_crc_en_i=1, the two bytes after the last FIFO byte are a CRC-16 over all popped bytes, taken before whitening. The CRC uses polynomial 0x8005 and initial value 0xFFFF. Each byte enters MSB first, with no reflection and no final XOR. The high byte goes first. With cfg_crc_en_i=0, no CRC bytes are sent.
- R6: With cfg_white_en_i=1, each byte after the sync word is XORed with bits [7:0] of a 9-bit state s. The state s is set to 0x1FF at start. After each such byte is sent, s takes 8 steps of s = {s[0]^s[5], s[8:1]}.
- R7: A byte transfers on a rising edge with tx_valid_o=1 and tx_ready_i=1. A non-FIFO byte keeps tx_valid_o and tx_data_o unchanged while it waits. fifo_rd_o is 1 exactly in the cycles where a FIFO byte transfers.
- R8: Suppose that in the length or payload phase tx_ready_i=1 while fifo_empty_i=1. Then underflow_o rises at the next cycle and stays 1. While it is 1, tx_valid_o and fifo_rd_o stay 0, and neither new FIFO data nor a start strobe has any effect.
- R9: A flush_i pulse returns the block to idle from any state in the following cycle. It clears underflow_o, and a later start then sends a complete packet.
- R10: done_o is a one-cycle pulse in the cycle after the last byte of a packet transfers. That last byte is the CRC low byte, or the last FIFO byte when the CRC is disabled. A start strobe during a packet is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, taken only in idle |
| flush_i | input | 1 | Abort and return to idle; clears underflow |
| cfg_var_len_i | input | 1 | 1: variable length (length byte first), 0: fixed length |
| cfg_fixed_len_i | input | 8 | Payload byte count in fixed mode |
| cfg_pre_count_i | input | PRE_CNT_W | Number of preamble bytes |
| cfg_sync_i | input | 16 | Sync word, sent high byte first |
| cfg_crc_en_i | input | 1 | Append CRC-16 |
| cfg_white_en_i | input | 1 | Whiten bytes after the sync word |
| fifo_empty_i | input | 1 | Transmit FIFO is empty |
| fifo_data_i | input | 8 | Byte at the FIFO head |
| fifo_rd_o | output | 1 | Pop the FIFO head |
| tx_data_o | output | 8 | Outgoing byte |
| tx_valid_o | output | 1 | tx_data_o holds a byte |
| tx_ready_i | input | 1 | Modulator accepts the byte |
| done_o | output | 1 | Packet-complete pulse |
| underflow_o | output | 1 | Sticky underflow state |

## Verification
The outgoing byte and fifo_rd_o come combinationally from the current state in the same cycle. A transfer takes effect at the rising edge where valid and ready are both high. done_o and underflow_o appear one cycle after their cause, and a flush has its effect one cycle after it is applied. The bench changes inputs just after a rising edge and compares every output against its reference model at the falling edge. A done pulse is therefore expected at the falling edge that follows the edge carrying the last transfer. The underflow and flush results are read one edge after the empty-with-ready condition or the flush pulse.

// File: rtl/pf_pkg.sv
package pf_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam logic [15:0] CRC_POLY = 16'h8005;
    localparam logic [15:0] CRC_INIT = 16'hFFFF;
    localparam logic [8:0]  PN9_SEED = 9'h1FF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_SYNC_HI,
        ST_SYNC_LO,
        ST_LEN,
        ST_PAY,
        ST_CRC_HI,
        ST_CRC_LO,
        ST_UFLOW
    } fr_state_e;

    // One outgoing byte slot, before whitening is applied
    typedef struct packed {
        logic  valid;
        byte_t data;
        logic  from_fifo;
        logic  scramble;
    } beat_t;

    function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in, input byte_t d);
        logic [15:0] c;
        logic        fb;
        c = crc_in;
        for (int i = 0; i < BYTE_W; i++) begin
            fb = c[15] ^ d[BYTE_W-1-i];
            c  = {c[14:0], 1'b0};
            if (fb) c = c ^ CRC_POLY;
        end
        return c;
    endfunction

    function automatic logic [8:0] pn9_adv8(input logic [8:0] s_in);
        logic [8:0] s;
        s = s_in;
        for (int i = 0; i < BYTE_W; i++) begin
            s = {s[0] ^ s[5], s[8:1]};
        end
        return s;
    endfunction

endpackage

// File: rtl/pf_crc16.sv
module pf_crc16
    import pf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        upd,
    input  byte_t       din,
    output logic [15:0] crc_o
);

    logic [15:0] crc_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            crc_q <= CRC_INIT;
        end else if (upd) begin
            crc_q <= crc16_byte(crc_q, din);
        end
    end

    assign crc_o = crc_q;

    // R5: a new packet always starts from the initial value
    assert_crc_seed_R5: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc_o == CRC_INIT));

endmodule

// File: rtl/pf_whiten.sv
module pf_whiten
    import pf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  seed,
    input  logic  adv,
    output byte_t mask_o
);

    logic [8:0] lfsr_q;

    always_ff @(posedge clk) begin
        if (rst || seed) begin
            lfsr_q <= PN9_SEED;
        end else if (adv) begin
            lfsr_q <= pn9_adv8(lfsr_q);
        end
    end

    assign mask_o = lfsr_q[BYTE_W-1:0];

    // R6: the first whitened byte of a packet uses the all-ones seed
    assert_pn9_seed_R6: assert property (@(posedge clk) disable iff (rst)
        seed |=> (mask_o == 8'hFF));

    // R6: the sequence only moves when a whitened byte is sent
    assert_pn9_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!seed && !adv) |=> $stable(mask_o));

endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
    import pf_pkg::*;
#(
    parameter int          PRE_CNT_W     = 4,
    parameter logic [7:0]  PREAMBLE_BYTE = 8'hAA
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 flush_i,
    input  logic                 cfg_var_len_i,
    input  logic [7:0]           cfg_fixed_len_i,
    input  logic [PRE_CNT_W-1:0] cfg_pre_count_i,
    input  logic [15:0]          cfg_sync_i,
    input  logic                 cfg_crc_en_i,
    input  logic                 cfg_white_en_i,
    input  logic                 fifo_empty_i,
    input  logic [7:0]           fifo_data_i,
    output logic                 fifo_rd_o,
    output logic [7:0]           tx_data_o,
    output logic                 tx_valid_o,
    input  logic                 tx_ready_i,
    output logic                 done_o,
    output logic                 underflow_o
);

    localparam logic [PRE_CNT_W-1:0] PRE_ONE  = PRE_CNT_W'(1);
    localparam logic [PRE_CNT_W-1:0] PRE_ZERO = '0;

    fr_state_e            state_q;
    logic [PRE_CNT_W-1:0] pre_cnt_q;
    byte_t                rem_q;
    logic                 done_q;

    beat_t       beat;
    logic        xfer;
    logic        starting;
    logic        starved;
    logic [15:0] crc_val;
    byte_t       wmask;

    assign starting = (state_q == ST_IDLE) && start_i && !flush_i;

    // Byte slot selected by the current phase
    always_comb begin
        beat = '0;
        unique case (state_q)
            ST_PRE: begin
                beat.valid = 1'b1;
                beat.data  = PREAMBLE_BYTE;
            end
            ST_SYNC_HI: begin
                beat.valid = 1'b1;
                beat.data  = cfg_sync_i[15:8];
            end
            ST_SYNC_LO: begin
                beat.valid = 1'b1;
                beat.data  = cfg_sync_i[7:0];
            end
            ST_LEN, ST_PAY: begin
                beat.valid     = !fifo_empty_i;
                beat.data      = fifo_data_i;
                beat.from_fifo = 1'b1;
                beat.scramble  = 1'b1;
            end
            ST_CRC_HI: begin
                beat.valid    = 1'b1;
                beat.data     = crc_val[15:8];
                beat.scramble = 1'b1;
            end
            ST_CRC_LO: begin
                beat.valid    = 1'b1;
                beat.data     = crc_val[7:0];
                beat.scramble = 1'b1;
            end
            default: beat = '0;
        endcase
    end

    assign tx_valid_o = beat.valid;
    assign tx_data_o  = (beat.scramble && cfg_white_en_i) ? (beat.data ^ wmask) : beat.data;
    assign xfer       = beat.valid && tx_ready_i;
    assign fifo_rd_o  = xfer && beat.from_fifo;
    assign starved    = beat.from_fifo && fifo_empty_i && tx_ready_i;

    pf_crc16 u_crc (
        .clk   (clk),
        .rst   (rst),
        .clr   (starting),
        .upd   (fifo_rd_o),
        .din   (fifo_data_i),
        .crc_o (crc_val)
    );

    pf_whiten u_wht (
        .clk    (clk),
        .rst    (rst),
        .seed   (starting),
        .adv    (xfer && beat.scramble),
        .mask_o (wmask)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pre_cnt_q <= PRE_ZERO;
            rem_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (flush_i) begin
                state_q <= ST_IDLE;
            end else begin
                unique case (state_q)
                    ST_IDLE: begin
                        if (start_i) begin
                            pre_cnt_q <= cfg_pre_count_i;
                            state_q   <= (cfg_pre_count_i == PRE_ZERO) ? ST_SYNC_HI : ST_PRE;
                        end
                    end
                    ST_PRE: begin
                        if (xfer) begin
                            pre_cnt_q <= pre_cnt_q - PRE_ONE;
                            if (pre_cnt_q == PRE_ONE) state_q <= ST_SYNC_HI;
                        end
                    end
                    ST_SYNC_HI: begin
                        if (xfer) state_q <= ST_SYNC_LO;
                    end
                    ST_SYNC_LO: begin
                        if (xfer) begin
                            if (cfg_var_len_i) begin
                                state_q <= ST_LEN;
                            end else if (cfg_fixed_len_i == '0) begin
                                state_q <= cfg_crc_en_i ? ST_CRC_HI : ST_IDLE;
                                done_q  <= !cfg_crc_en_i;
                            end else begin
                                rem_q   <= cfg_fixed_len_i;
                                state_q <= ST_PAY;
                            end
                        end
                    end
                    ST_LEN: begin
                        if (xfer) begin
                            rem_q <= fifo_data_i;
                            if (fifo_data_i == '0) begin
                                state_q <= cfg_crc_en_i ? ST_CRC_HI : ST_IDLE;
                                done_q  <= !cfg_crc_en_i;
                            end else begin
                                state_q <= ST_PAY;
                            end
                        end else if (starved) begin
                            state_q <= ST_UFLOW;
                        end
                    end
                    ST_PAY: begin
                        if (xfer) begin
                            rem_q <= rem_q - 8'd1;
                            if (rem_q == 8'd1) begin
                                state_q <= cfg_crc_en_i ? ST_CRC_HI : ST_IDLE;
                                done_q  <= !cfg_crc_en_i;
                            end
                        end else if (starved) begin
                            state_q <= ST_UFLOW;
                        end
                    end
                    ST_CRC_HI: begin
                        if (xfer) state_q <= ST_CRC_LO;
                    end
                    ST_CRC_LO: begin
                        if (xfer) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                    ST_UFLOW: state_q <= ST_UFLOW;
                    default:  state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign done_o      = done_q;
    assign underflow_o = (state_q == ST_UFLOW);

    // R7: a non-FIFO byte waits unchanged until it is taken
    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready_i && !flush_i &&
         (state_q inside {ST_PRE, ST_SYNC_HI, ST_SYNC_LO, ST_CRC_HI, ST_CRC_LO}))
        |=> (tx_valid_o && $stable(tx_data_o)));

    // R7: the FIFO is never popped while it is empty
    assert_no_empty_pop_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_rd_o |-> !fifo_empty_i);

    // R8: underflow is sticky until a flush
    assert_uflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (underflow_o && !flush_i) |=> underflow_o);

    // R8: nothing leaves and nothing is popped while locked
    assert_uflow_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        underflow_o |-> (!tx_valid_o && !fifo_rd_o));

    // R9: a flush lands in idle
    assert_flush_idle_R9: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (!underflow_o && !tx_valid_o && !done_o));

    // R10: done is a single-cycle pulse that follows a transfer
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_cause_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(tx_valid_o && tx_ready_i));

endmodule

// File: tb/sim_pkt_framer.sv
`timescale 1ns/1ps
module sim_pkt_framer;

    localparam int PRE_CNT_W = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start_i = 1'b0;
    logic                 flush_i = 1'b0;
    logic                 cfg_var_len_i = 1'b1;
    logic [7:0]           cfg_fixed_len_i = 8'd0;
    logic [PRE_CNT_W-1:0] cfg_pre_count_i = '0;
    logic [15:0]          cfg_sync_i = 16'hD391;
    logic                 cfg_crc_en_i = 1'b1;
    logic                 cfg_white_en_i = 1'b0;
    logic                 fifo_empty_i = 1'b1;
    logic [7:0]           fifo_data_i = 8'd0;
    logic                 fifo_rd_o;
    logic [7:0]           tx_data_o;
    logic                 tx_valid_o;
    logic                 tx_ready_i = 1'b1;
    logic                 done_o;
    logic                 underflow_o;

    always #2 clk = ~clk;   // 250 MHz

    pkt_framer #(.PRE_CNT_W(PRE_CNT_W)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .flush_i(flush_i),
        .cfg_var_len_i(cfg_var_len_i), .cfg_fixed_len_i(cfg_fixed_len_i),
        .cfg_pre_count_i(cfg_pre_count_i), .cfg_sync_i(cfg_sync_i),
        .cfg_crc_en_i(cfg_crc_en_i), .cfg_white_en_i(cfg_white_en_i),
        .fifo_empty_i(fifo_empty_i), .fifo_data_i(fifo_data_i), .fifo_rd_o(fifo_rd_o),
        .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_ready_i(tx_ready_i),
        .done_o(done_o), .underflow_o(underflow_o)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int ready_mode = 0;
    bit exp_done = 1'b0;
    bit pkt_full = 1'b0;

    logic [7:0] fq[$];      // behavioural FIFO contents
    logic [7:0] exp_d[$];   // expected outgoing bytes
    bit         exp_f[$];   // expected byte comes from the FIFO
    string      exp_t[$];   // requirement tag of each expected byte

    task automatic chk(input bit ok, input string req, input int act, input int expv, input string what);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic fifo_sync();
        fifo_empty_i = (fq.size() == 0);
        fifo_data_i  = (fq.size() != 0) ? fq[0] : 8'h00;
    endtask

    // One clock: compare at the falling edge, update the FIFO after the rising edge
    task automatic tick();
        bit xfer;
        bit rd;
        @(negedge clk);
        chk(done_o == exp_done, "R10", done_o, exp_done, "done pulse");
        exp_done = 1'b0;
        if (tx_valid_o) begin
            if (exp_d.size() == 0)
                chk(1'b0, "R8", tx_data_o, 0, "unexpected valid byte");
            else
                chk(tx_data_o == exp_d[0], exp_t[0], tx_data_o, exp_d[0], "byte value");
        end
        xfer = tx_valid_o && tx_ready_i;
        chk(fifo_rd_o == (xfer && exp_f.size() != 0 && exp_f[0]), "R7",
            fifo_rd_o, (xfer && exp_f.size() != 0 && exp_f[0]), "fifo pop");
        rd = fifo_rd_o;
        if (xfer && exp_d.size() != 0) begin
            void'(exp_d.pop_front());
            void'(exp_f.pop_front());
            void'(exp_t.pop_front());
            if (exp_d.size() == 0 && pkt_full) exp_done = 1'b1;
        end
        @(posedge clk);
        #1;
        if (rd && fq.size() != 0) void'(fq.pop_front());
        fifo_sync();
        cyc++;
        tx_ready_i = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c_in, input logic [7:0] d);
        int c;
        c = c_in;
        for (int b = 7; b >= 0; b--) begin
            bit top;
            top = ((c >> 15) & 1) ^ ((d >> b) & 1);
            c = (c << 1) & 16'hFFFF;
            if (top) c = c ^ 16'h8005;
        end
        return c[15:0];
    endfunction

    // Reference: expected bytes from the configuration and the FIFO contents
    function automatic int build_expected();
        int count, avail, s;
        logic [15:0] c;
        string ptag;
        count = cfg_var_len_i ? (int'(fq.size() != 0 ? fq[0] : 8'd0) + 1) : int'(cfg_fixed_len_i);
        avail = (count < fq.size()) ? count : fq.size();
        pkt_full = (avail == count);
        ptag = cfg_white_en_i ? "R6" : (cfg_var_len_i ? "R3" : "R4");
        for (int i = 0; i < int'(cfg_pre_count_i); i++) begin
            exp_d.push_back(8'hAA); exp_f.push_back(1'b0); exp_t.push_back("R2");
        end
        exp_d.push_back(cfg_sync_i[15:8]); exp_f.push_back(1'b0); exp_t.push_back("R2");
        exp_d.push_back(cfg_sync_i[7:0]);  exp_f.push_back(1'b0); exp_t.push_back("R2");
        s = 9'h1FF;
        c = 16'hFFFF;
        for (int i = 0; i < avail + ((pkt_full && cfg_crc_en_i) ? 2 : 0); i++) begin
            logic [7:0] d;
            if (i < avail) begin
                d = fq[i];
                c = ref_crc(c, d);
            end else begin
                d = (i == avail) ? c[15:8] : c[7:0];
            end
            exp_d.push_back(cfg_white_en_i ? (d ^ s[7:0]) : d);
            exp_f.push_back(i < avail);
            exp_t.push_back((i < avail) ? ptag : "R5");
            for (int k = 0; k < 8; k++) s = ((((s >> 0) ^ (s >> 5)) & 1) << 8) | (s >> 1);
        end
        return fq.size() - avail;
    endfunction

    task automatic run_pkt(input bit var_m, input logic [7:0] fixed_n, input int pre,
                           input bit crc_en, input bit wh_en, input int rmode, input bit poke_start);
        int left;
        int guard;
        cfg_var_len_i   = var_m;
        cfg_fixed_len_i = fixed_n;
        cfg_pre_count_i = PRE_CNT_W'(pre);
        cfg_crc_en_i    = crc_en;
        cfg_white_en_i  = wh_en;
        ready_mode      = rmode;
        left = build_expected();
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        guard = 0;
        while (exp_d.size() != 0 && guard < 2000) begin
            if (poke_start && guard == 5) start_i = 1'b1;   // R10: start while busy
            tick();
            start_i = 1'b0;
            guard++;
        end
        chk(exp_d.size() == 0, var_m ? "R3" : "R4", exp_d.size(), 0, "bytes still owed");
        tick();
        tick();
        if (pkt_full)
            chk(fq.size() == left, var_m ? "R3" : "R4", fq.size(), left, "FIFO bytes left over");
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R1: reset state, with data waiting in the FIFO
        fq.push_back(8'h11);
        fifo_sync();
        repeat (3) @(posedge clk);
        #1;
        chk(tx_valid_o == 1'b0,  "R1", tx_valid_o, 0, "valid in reset");
        chk(fifo_rd_o == 1'b0,   "R1", fifo_rd_o, 0, "pop in reset");
        chk(done_o == 1'b0,      "R1", done_o, 0, "done in reset");
        chk(underflow_o == 1'b0, "R1", underflow_o, 0, "underflow in reset");
        rst = 1'b0;
        repeat (4) tick();
        chk(fq.size() == 1, "R1", fq.size(), 1, "FIFO untouched before start");
        fq.delete();
        fifo_sync();

        // R3 R5 R10: variable length, CRC, a stray start mid-packet, extra FIFO byte left
        fq = '{8'h04, 8'h5A, 8'h01, 8'h02, 8'h03, 8'hEE};
        fifo_sync();
        run_pkt(1'b1, 8'd0, 3, 1'b1, 1'b0, 0, 1'b1);
        fq.delete(); fifo_sync();

        // R4 R6 R5 R7: fixed length, whitened, stalls from the modulator
        fq = '{8'h10, 8'h20, 8'h30, 8'h40, 8'h50};
        fifo_sync();
        run_pkt(1'b0, 8'd5, 2, 1'b1, 1'b1, 1, 1'b0);

        // R3 R6: length byte of 0, no preamble, no CRC
        fq = '{8'h00, 8'h77};
        fifo_sync();
        run_pkt(1'b1, 8'd0, 0, 1'b0, 1'b1, 0, 1'b0);
        fq.delete(); fifo_sync();

        // R4 R5: fixed length 0 sends only the CRC of nothing
        run_pkt(1'b0, 8'd0, 1, 1'b1, 1'b0, 1, 1'b0);

        // R8: the FIFO runs dry after two payload bytes
        fq = '{8'h06, 8'hA1, 8'hA2};
        fifo_sync();
        run_pkt(1'b1, 8'd0, 2, 1'b1, 1'b0, 0, 1'b0);
        chk(underflow_o == 1'b1, "R8", underflow_o, 1, "underflow entered");
        fq = '{8'hB1, 8'hB2, 8'hB3, 8'hB4};
        fifo_sync();
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        repeat (8) tick();
        chk(underflow_o == 1'b1, "R8", underflow_o, 1, "underflow still held");
        chk(fq.size() == 4, "R8", fq.size(), 4, "no pops while locked");

        // R9: flush releases the lock
        flush_i = 1'b1;
        tick();
        flush_i = 1'b0;
        chk(underflow_o == 1'b0, "R9", underflow_o, 0, "underflow cleared by flush");
        chk(tx_valid_o == 1'b0,  "R9", tx_valid_o, 0, "idle after flush");
        fq.delete(); fifo_sync();
        fq = '{8'h02, 8'hC1, 8'hC2};
        fifo_sync();
        run_pkt(1'b1, 8'd0, 1, 1'b1, 1'b1, 0, 1'b0);

        // R9: flush in the middle of the preamble
        fq = '{8'h01, 8'hD1};
        fifo_sync();
        cfg_pre_count_i = PRE_CNT_W'(6);
        cfg_var_len_i   = 1'b1;
        cfg_white_en_i  = 1'b0;
        void'(build_expected());
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        tick();
        flush_i = 1'b1;
        tick();
        flush_i = 1'b0;
        exp_d.delete(); exp_f.delete(); exp_t.delete();
        pkt_full = 1'b0;
        chk(tx_valid_o == 1'b0, "R9", tx_valid_o, 0, "flush stops the preamble");
        repeat (3) tick();
        chk(fq.size() == 2, "R9", fq.size(), 2, "no pops after flush");
        run_pkt(1'b1, 8'd0, 2, 1'b1, 1'b0, 1, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule